// File: doc/BRIEF.md
# Saturating Up/Down Counter

This block is a synchronous binary counter. A single mode input sets the direction on every clock edge. It steps one code up or one code down per edge. It never wraps around. When it climbs to the all-ones code it stays there. When it falls to zero it stays there. Two status outputs show when the counter sits at either end, so surrounding logic can see that the clamp is active without decoding the count itself.

The state is one registered vector. Combinational logic sorts the current count into one of three zones, and the next-state logic uses that zone and the direction to pick the next value:

- `ZONE_FLOOR`: count is zero.
- `ZONE_SPAN`: count is strictly between the ends.
- `ZONE_CEIL`: count is all ones.

The transitions are:

- STEP_UP: span or floor, with mode 0, goes to count + 1.
- STEP_DOWN: span or ceiling, with mode 1, goes to count - 1.
- HOLD_CEIL: ceiling with mode 0 stays at all ones.
- HOLD_FLOOR: floor with mode 1 stays at zero.
- RESET: any zone goes to zero while reset is high.

A synchronous active-high reset clears the count and overrides the mode. The width is a parameter that defaults to 4 bits.

Top module: `sat_updown_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 after that edge, whatever the value of `mode`.
- R2: With `rst` low and `mode` = 0, a count from 0 through 14 becomes count + 1 at the next edge.
- R3: With `rst` low and `mode` = 0, a count of 15 stays 15; it never wraps to 0.
- R4: With `rst` low and `mode` = 1, a count from 15 down through 1 becomes count - 1 at the next edge.
- R5: With `rst` low and `mode` = 1, a count of 0 stays 0; it never wraps to 15.
- R6: `at_max` is 1 exactly when `count` is 15 (binary 1111), in the same cycle.
- R7: `at_min` is 1 exactly when `count` is 0, in the same cycle.
- R8: A change of `mode` takes effect at the very next rising edge, even when `mode` toggles every cycle.
- R9: Between two consecutive edges the count changes by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | 4 | Registered count value, bit 3 is the MSB |
| at_max | output | 1 | High while the count is all ones |
| at_min | output | 1 | High while the count is zero |

## Verification
The count register is the only storage. A value of `rst` or `mode` presented before an edge is therefore visible on `count` one edge later. Both flags are decoded from the register and follow in that same cycle, with no extra delay. The bench drives inputs on the falling edge and samples all three outputs 1 ns after the next rising edge. It compares them with a step-by-step reference that it advances by exactly one edge per driven cycle, so every result is checked in the cycle it is due.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ZONE_FLOOR = 2'd0,
        ZONE_SPAN  = 2'd1,
        ZONE_CEIL  = 2'd2
    } zone_e;

endpackage

// File: rtl/sat_cnt_zone.sv
module sat_cnt_zone
    import sat_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output zone_e            zone
);
    localparam logic [WIDTH-1:0] CEIL_CODE  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] FLOOR_CODE = '0;

    always_comb begin
        if (cur == CEIL_CODE)
            zone = ZONE_CEIL;
        else if (cur == FLOOR_CODE)
            zone = ZONE_FLOOR;
        else
            zone = ZONE_SPAN;
    end
endmodule

// File: rtl/sat_cnt_next.sv
module sat_cnt_next
    import sat_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  zone_e            zone,
    input  dir_e             dir,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);

    always_comb begin
        nxt = cur;
        unique case (zone)
            ZONE_FLOOR: nxt = (dir == DIR_UP)   ? cur + UNIT : cur;
            ZONE_CEIL:  nxt = (dir == DIR_DOWN) ? cur - UNIT : cur;
            ZONE_SPAN:  nxt = (dir == DIR_UP)   ? cur + UNIT : cur - UNIT;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/sat_cnt_flags.sv
module sat_cnt_flags
    import sat_cnt_pkg::*;
(
    input  zone_e zone,
    output logic  top_flag,
    output logic  bottom_flag
);
    always_comb begin
        top_flag    = 1'b0;
        bottom_flag = 1'b0;
        unique case (zone)
            ZONE_CEIL:  top_flag    = 1'b1;
            ZONE_FLOOR: bottom_flag = 1'b1;
            ZONE_SPAN:  ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/sat_updown_counter.sv
module sat_updown_counter
    import sat_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    output logic [WIDTH-1:0] count,
    output logic             at_max,
    output logic             at_min
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    zone_e            zone;
    dir_e             dir;

    assign dir = dir_e'(mode);

    sat_cnt_zone #(.WIDTH(WIDTH)) u_zone (
        .cur  (state_q),
        .zone (zone)
    );

    sat_cnt_next #(.WIDTH(WIDTH)) u_next (
        .cur  (state_q),
        .zone (zone),
        .dir  (dir),
        .nxt  (state_d)
    );

    sat_cnt_flags u_flags (
        .zone        (zone),
        .top_flag    (at_max),
        .bottom_flag (at_min)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign count = state_q;
endmodule

// File: rtl/sat_updown_counter_chk.sv
module sat_updown_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode,
    input logic [WIDTH-1:0] count,
    input logic             at_max,
    input logic             at_min
);
    localparam logic [WIDTH-1:0] CEIL_CODE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] UNIT      = WIDTH'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> count == '0); // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (!mode && count != CEIL_CODE) |=> count == $past(count) + UNIT); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!mode && count == CEIL_CODE) |=> count == CEIL_CODE); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (mode && count != '0) |=> count == $past(count) - UNIT); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (mode && count == '0) |=> count == '0); // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({at_max, at_min})); // R6
    AST_MAX_TO_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (at_max && !mode) |=> at_max); // R6
    AST_MIN_TO_DOWN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (at_min && mode) |=> at_min); // R7
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + UNIT
                  || count == $past(count) - UNIT)); // R9
endmodule

bind sat_updown_counter sat_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .count  (count),
    .at_max (at_max),
    .at_min (at_min)
);

// File: tb/tb_sat_updown_counter.sv
`timescale 1ns/1ps
module tb_sat_updown_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic [3:0] count;
    logic       at_max;
    logic       at_min;

    int n_run  = 0;
    int n_fail = 0;
    int ref_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sat_updown_counter dut (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .count  (count),
        .at_max (at_max),
        .at_min (at_min)
    );

    // {rst, mode, cycles[5:0], expected count at end[3:0]}
    localparam int NV = 11;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd2,  4'd0},
        {1'b0, 1'b0, 6'd5,  4'd5},
        {1'b0, 1'b1, 6'd2,  4'd3},
        {1'b0, 1'b0, 6'd20, 4'd15},
        {1'b0, 1'b1, 6'd3,  4'd12},
        {1'b0, 1'b1, 6'd30, 4'd0},
        {1'b0, 1'b0, 6'd1,  4'd1},
        {1'b1, 1'b1, 6'd1,  4'd0},
        {1'b0, 1'b0, 6'd14, 4'd14},
        {1'b0, 1'b0, 6'd1,  4'd15},
        {1'b1, 1'b0, 6'd1,  4'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic one_cycle(input logic r, input logic m, input string step_tag);
        int prev;
        prev = ref_cnt;
        @(negedge clk);
        rst  = r;
        mode = m;
        if (r) ref_cnt = 0;
        else if (!m) ref_cnt = (ref_cnt == 15) ? 15 : ref_cnt + 1;
        else ref_cnt = (ref_cnt == 0) ? 0 : ref_cnt - 1;
        @(posedge clk);
        #1;
        check(step_tag, int'(count), ref_cnt);
        check("R6 at_max", int'(at_max), (ref_cnt == 15) ? 1 : 0);
        check("R7 at_min", int'(at_min), (ref_cnt == 0) ? 1 : 0);
        if (!r) begin
            int d;
            d = int'(count) - prev;
            check("R9 step size", (d >= -1 && d <= 1) ? 1 : 0, 1);
        end
    endtask

    function automatic string tag_for(input logic r, input logic m);
        if (r) return "R1 reset";
        if (!m) return (ref_cnt == 15) ? "R3 hold top" : "R2 step up";
        return (ref_cnt == 0) ? "R5 hold bottom" : "R4 step down";
    endfunction

    initial begin
        // reset state
        @(posedge clk);
        #1;
        check("R1 reset count", int'(count), 0);
        check("R7 reset at_min", int'(at_min), 1);
        check("R6 reset at_max", int'(at_max), 0);
        ref_cnt = 0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            for (int c = 0; c < int'(VEC[i][9:4]); c++)
                one_cycle(VEC[i][11], VEC[i][10], tag_for(VEC[i][11], VEC[i][10]));
            check("R2/R4 vector endpoint", int'(count), int'(VEC[i][3:0]));
        end

        // R8: direction toggles every cycle from 7
        one_cycle(1'b1, 1'b0, "R1 reset");
        for (int k = 0; k < 7; k++) one_cycle(1'b0, 1'b0, "R2 step up");
        one_cycle(1'b0, 1'b1, "R8 toggle down");
        check("R8 after toggle", int'(count), 6);
        one_cycle(1'b0, 1'b0, "R8 toggle up");
        check("R8 after toggle", int'(count), 7);
        one_cycle(1'b0, 1'b1, "R8 toggle down");
        check("R8 after toggle", int'(count), 6);

        // R3/R8: toggling at the top boundary
        for (int k = 0; k < 12; k++) one_cycle(1'b0, 1'b0, tag_for(1'b0, 1'b0));
        one_cycle(1'b0, 1'b0, "R3 hold top");
        one_cycle(1'b0, 1'b1, "R8 leave top");
        check("R8 left top", int'(count), 14);

        // R1: reset while counting down from mid range
        one_cycle(1'b1, 1'b1, "R1 reset over down");
        one_cycle(1'b0, 1'b1, "R5 hold bottom");
        check("R5 bottom after reset", int'(count), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule